// File: doc/BRIEF.md
# Majority-Vote Input Debouncer with Hysteresis

This block cleans up one noisy, asynchronous digital input. The raw pin first passes through a short synchronizer chain. It is then sampled on every clock into a window of the most recent `WIN_LEN` samples. The number of ones held in that window is kept as a count. A registered level output switches only when the count clearly leans one way. It goes high when the count is above `WIN_LEN/2 + MARGIN` and low when the count is below `WIN_LEN/2 - MARGIN`. Inside that band it keeps its last value.

The clock is expected to run several times faster than the input can legitimately toggle. Short glitches and bounces therefore shift the count a little but do not move the output. The window length, the dead-band margin and the synchronizer depth are parameters. `COUNT_MODE` selects how the count is formed: a full population count of the window, or a running up/down counter that adds the incoming sample and drops the outgoing one. Both variants behave identically at the ports. The live count is exposed as `win_count` so that a neighbouring block can watch how firmly the input is held. The block has no data stream, so every pin is a plain level signal.

All thresholds use integer division: half the window is `WIN_LEN/2`, rounded down. Elaboration fails unless `WIN_LEN >= 3`, `SYNC_STAGES >= 2` and `MARGIN < WIN_LEN/2`. These limits keep the lower threshold at 1 or more, so the output can always be cleared.

Top module: `mvd_debounce`

## Requirements
- R1: While `rst` is high at a rising clock edge, the synchronizer, the window, the count and `level_out` are all cleared to 0.
- R2: With the default `SYNC_STAGES` = 2, a value driven on `raw_in` before rising edge k first enters the window at edge k+2, so `win_count` reflects it after edge k+2.
- R3: `win_count` equals the number of ones among the last `WIN_LEN` synchronized samples. It lies in 0..`WIN_LEN`, changes by at most 1 per clock, and is the same under both `COUNT_MODE` values (0 = population count, 1 = running counter).
- R4: When `win_count` is greater than `WIN_LEN/2 + MARGIN` at an edge, `level_out` is 1 after that edge. With the defaults (8, 1), a steady 1 after reset raises `level_out` at the 9th edge.
- R5: When `win_count` is less than `WIN_LEN/2 - MARGIN` at an edge, `level_out` is 0 after that edge. With the defaults, a steady 0 after a full window of ones clears `level_out` at the 9th edge.
- R6: When `win_count` lies between the two thresholds inclusive, `level_out` keeps its value. A dip of 4 low samples into a full window of ones leaves the output at 1.
- R7: Starting from a settled 0, an isolated high pulse of at most `WIN_LEN/2 + MARGIN` samples never raises `level_out`. A pulse one sample longer does raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the input on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Raw asynchronous input to be filtered |
| level_out | output | 1 | Debounced level, registered |
| win_count | output | $clog2(WIN_LEN+1) | Number of ones in the current sample window |

## Verification
On every cycle, the embedded properties check that each synchronizer stage advances and that the window shifts the synchronized sample into place. They also check that the count stays within the window size and moves by at most one step, and that the running counter always agrees with a population count of the window. The output register is checked on every cycle against the two thresholds and the hold band. Only the bench scenarios can show the end-to-end latencies from the pin. They alone show that a short glitch cannot reach the output while one sample more can, and that both count variants match a reference model under long bursty random traffic.

// File: rtl/mvd_pkg.sv
package mvd_pkg;

  // Decision taken by the output stage from the current window count.
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_SET  = 2'd1,
    DEC_CLR  = 2'd2
  } mvd_dec_e;

  // Width needed to hold every value from 0 to n inclusive.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/mvd_sync.sv
module mvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '0;
    else     ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];

  // R1 / R2: the last stage always carries what the stage before it held one clock earlier.
  a_r2_sync_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ff_q[STAGES-1] == $past(ff_q[STAGES-2]));

endmodule

// File: rtl/mvd_window.sv
module mvd_window #(
  parameter int N          = 8,
  parameter int CW         = 4,
  parameter int COUNT_MODE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_i,
  output logic [CW-1:0] cnt_o
);

  logic [N-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= {win_q[N-2:0], s_i};
  end

  generate
    if (COUNT_MODE == 0) begin : g_popcount
      logic [CW-1:0] sum;
      always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) sum = sum + CW'(win_q[i]);
      end
      assign cnt_o = sum;
    end else begin : g_running
      logic [CW-1:0] run_q;
      always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_q + CW'(s_i) - CW'(win_q[N-1]);
      end
      assign cnt_o = run_q;

      // R3: the running counter never drifts from the true number of ones in the window.
      a_r3_running_tracks: assert property (@(posedge clk) disable iff (rst)
        int'(run_q) == $countones(win_q));
    end
  endgenerate

  // R2: the newest window slot holds the synchronized sample of the previous clock.
  a_r2_window_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> win_q[0] == $past(s_i));

  // R3: the count can never exceed the window size.
  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_o) <= N);

  // R3: one sample in and one out moves the count by at most one.
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, cnt_o} == {1'b0, $past(cnt_o)}) ||
             ({1'b0, cnt_o} == {1'b0, $past(cnt_o)} + (CW+1)'(1)) ||
             ({1'b0, cnt_o} + (CW+1)'(1) == {1'b0, $past(cnt_o)}));

endmodule

// File: rtl/mvd_hyst.sv
module mvd_hyst
  import mvd_pkg::*;
#(
  parameter int CW    = 4,
  parameter int TH_HI = 5,
  parameter int TH_LO = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  output logic          level_o
);

  localparam logic [CW-1:0] HI_V = CW'(TH_HI);
  localparam logic [CW-1:0] LO_V = CW'(TH_LO);

  mvd_dec_e dec;
  logic     level_q;

  always_comb begin
    if (cnt_i > HI_V)      dec = DEC_SET;
    else if (cnt_i < LO_V) dec = DEC_CLR;
    else                   dec = DEC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
    end else begin
      case (dec)
        DEC_SET:  level_q <= 1'b1;
        DEC_CLR:  level_q <= 1'b0;
        default:  level_q <= level_q;
      endcase
    end
  end

  assign level_o = level_q;

  // R4: a count above the upper threshold drives the output high on the next clock.
  a_r4_set_above: assert property (@(posedge clk) disable iff (rst)
    (cnt_i > HI_V) |=> level_q);

  // R5: a count below the lower threshold drives the output low on the next clock.
  a_r5_clear_below: assert property (@(posedge clk) disable iff (rst)
    (cnt_i < LO_V) |=> !level_q);

  // R6: inside the dead band the output does not move.
  a_r6_hold_band: assert property (@(posedge clk) disable iff (rst)
    (cnt_i >= LO_V && cnt_i <= HI_V) |=> $stable(level_q));

endmodule

// File: rtl/mvd_debounce.sv
module mvd_debounce
  import mvd_pkg::*;
#(
  parameter int WIN_LEN     = 8,
  parameter int MARGIN      = 1,
  parameter int SYNC_STAGES = 2,
  parameter int COUNT_MODE  = 0,
  localparam int CW         = count_width(WIN_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          raw_in,
  output logic          level_out,
  output logic [CW-1:0] win_count
);

  localparam int HALF  = WIN_LEN / 2;
  localparam int TH_HI = HALF + MARGIN;
  localparam int TH_LO = HALF - MARGIN;

  generate
    if (WIN_LEN < 3 || SYNC_STAGES < 2 || MARGIN < 0 || MARGIN >= HALF) begin : g_bad_params
      $error("mvd_debounce: need WIN_LEN>=3, SYNC_STAGES>=2, 0<=MARGIN<WIN_LEN/2");
    end
  endgenerate

  logic sync_s;

  mvd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_s)
  );

  mvd_window #(
    .N          (WIN_LEN),
    .CW         (CW),
    .COUNT_MODE (COUNT_MODE)
  ) u_window (
    .clk   (clk),
    .rst   (rst),
    .s_i   (sync_s),
    .cnt_o (win_count)
  );

  mvd_hyst #(
    .CW    (CW),
    .TH_HI (TH_HI),
    .TH_LO (TH_LO)
  ) u_hyst (
    .clk     (clk),
    .rst     (rst),
    .cnt_i   (win_count),
    .level_o (level_out)
  );

endmodule

// File: tb/mvd_debounce_bench.sv
`timescale 1ns/1ps
module mvd_debounce_bench;

  localparam int N  = 8;
  localparam int E  = 1;
  localparam int CW = $clog2(N + 1);
  localparam int HI = N / 2 + E;
  localparam int LO = N / 2 - E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic lvl_a, lvl_b;
  logic [CW-1:0] cnt_a, cnt_b;
  logic done = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 8 ns period

  mvd_debounce #(.WIN_LEN(N), .MARGIN(E), .SYNC_STAGES(2), .COUNT_MODE(0)) u_mvd_debounce (
    .clk(clk), .rst(rst), .raw_in(raw), .level_out(lvl_a), .win_count(cnt_a));

  mvd_debounce #(.WIN_LEN(N), .MARGIN(E), .SYNC_STAGES(2), .COUNT_MODE(1)) u_mvd_debounce_run (
    .clk(clk), .rst(rst), .raw_in(raw), .level_out(lvl_b), .win_count(cnt_b));

  // Reference model state, built from the requirements.
  logic         m_s1 = 1'b0, m_s2 = 1'b0;
  logic [N-1:0] m_win = '0;
  logic         m_out = 1'b0, m_prev = 1'b0;

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic next_level(input int c, input logic cur);
    if (c > HI) return 1'b1;
    if (c < LO) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_win = '0; m_out = 1'b0; m_prev = 1'b0;
    end else begin
      m_prev = m_out;
      m_out  = next_level(ones(m_win), m_out);
      m_win  = {m_win[N-2:0], m_s2};
      m_s2   = m_s1;
      m_s1   = raw;
    end
  end

  // Continuous comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 count (popcount)", int'(cnt_a), ones(m_win));
      check("R3 count (running)",  int'(cnt_b), ones(m_win));
      if (m_out && !m_prev) begin
        check("R4 set", int'(lvl_a), 1);
        check("R4 set (running)", int'(lvl_b), 1);
      end else if (!m_out && m_prev) begin
        check("R5 clear", int'(lvl_a), 0);
        check("R5 clear (running)", int'(lvl_b), 0);
      end else begin
        check("R6 hold", int'(lvl_a), int'(m_out));
        check("R6 hold (running)", int'(lvl_b), int'(m_out));
      end
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    wait_n(3);
    check("R1 level in reset", int'(lvl_a), 0);
    check("R1 count in reset", int'(cnt_a), 0);
    check("R1 count in reset (running)", int'(cnt_b), 0);
    rst = 1'b0;
    wait_n(2);
    check("R1 level after reset", int'(lvl_a), 0);

    // R2 / R4: steady high after reset
    raw = 1'b1;
    wait_n(1); check("R2 count after edge 1", int'(cnt_a), 0);
    wait_n(1); check("R2 count after edge 2", int'(cnt_a), 0);
    wait_n(1); check("R2 count after edge 3", int'(cnt_a), 1);
    wait_n(5); check("R4 level after edge 8", int'(lvl_a), 0);
    check("R4 count after edge 8", int'(cnt_a), 6);
    wait_n(1); check("R4 level after edge 9", int'(lvl_a), 1);
    wait_n(3); check("R3 full window", int'(cnt_a), N);

    // R5: steady low from a full window
    raw = 1'b0;
    wait_n(8); check("R5 level after edge 8", int'(lvl_a), 1);
    check("R5 count after edge 8", int'(cnt_a), 2);
    wait_n(1); check("R5 level after edge 9", int'(lvl_a), 0);
    wait_n(4); check("R3 empty window", int'(cnt_a), 0);

    // R6: a dip into the dead band keeps the output high
    raw = 1'b1;
    wait_n(14); check("R6 settled high", int'(lvl_a), 1);
    raw = 1'b0;
    wait_n(4);
    raw = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R6 dip held high", int'(lvl_a), 1);
    end
    raw = 1'b0;
    wait_n(14); check("R6 settled low", int'(lvl_a), 0);

    // R7: pulse of HI samples is rejected, HI+1 is accepted
    raw = 1'b1;
    wait_n(HI);
    raw = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R7 short pulse rejected", int'(lvl_a), 0);
    end
    begin
      logic seen = 1'b0;
      raw = 1'b1;
      wait_n(HI + 1);
      raw = 1'b0;
      for (int i = 0; i < 14; i++) begin
        @(negedge clk);
        if (lvl_a) seen = 1'b1;
      end
      check("R7 pulse one longer accepted", int'(seen), 1);
    end
    wait_n(14);

    // Bursty random traffic: noisy phases and quiet phases
    for (int ph = 0; ph < 40; ph++) begin
      int pct = (ph % 2 == 0) ? 35 : 4;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (($urandom % 100) < pct) raw = ~raw;
      end
    end
    wait_n(16);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule